// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer peripheral on a simple word-addressed register bus. Software programs a reload value and a prescaler, then starts the timer with a two-word key written to a key register. Once it is started, a counter climbs from the reload value on a slow base tick, which comes in as a one-cycle strobe. If software does not service the timer in time, the counter rolls past its top value and the block pulses a reset output. Software services the timer by writing a kick register with a value that differs from the previous kick.

Every register write is posted. The write first sits in a per-register holding slot, and the slot's bit in the pending register stays high for a fixed number of clock cycles. The value is applied only when that bit clears. This stands in for a crossing into a slower timer domain. Stopping the timer takes a second two-word key. Configuration writes that land while the timer runs are discarded.

A 60-second timeout at the 32768 Hz base tick with the prescaler off needs a reload value of 2^32 − 60·32768 = 0xFFE20000. Other timeouts are set the same way through the reload value and the prescale exponent.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the timer is stopped, and CTRL, LOAD, COUNT and PEND all read 0. The reset output is low.
- R2: The word addresses are 0 CTRL (bit0 prescaler enable, bits 3:1 prescale exponent), 1 LOAD, 2 COUNT (read-only; writes to it are ignored), 3 KICK, 4 KEY and 5 PEND. The PEND bits are bit0 CTRL, bit1 LOAD, bit2 KICK and bit3 KEY.
- R3: A write to CTRL, LOAD, KICK or KEY sets that register's PEND bit for PEND_CYC (default 4) clock cycles. The written value takes effect in the cycle the bit clears.
- R4: A write to a register whose PEND bit is set is dropped.
- R5: A committed KEY write of 0xBBBB, followed by a committed KEY write of 0x4444, starts the timer and loads COUNT from LOAD.
- R6: A committed KEY write of 0xAAAA, followed by a committed KEY write of 0x5555, stops the timer. Any other value, or any other order, leaves the run state unchanged.
- R7: Committed writes to CTRL or LOAD while the timer runs leave those registers unchanged.
- R8: A committed KICK value that differs from the last committed KICK value loads COUNT from LOAD. Repeating the same value has no effect. The last KICK value is 0 after reset.
- R9: While the timer runs, COUNT rises by one on every tick when the prescaler is off, and by one every 2^exponent ticks when it is on. While the timer is stopped, COUNT holds.
- R10: An advance from 0xFFFFFFFF raises the reset output for exactly one cycle and loads COUNT from LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| tick_i | input | 1 | Base tick strobe, one clock wide |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions assume that bus_wr and tick_i are single-cycle strobes sampled on the rising edge. They also assume that reset is applied before any traffic. The bench drives every input on the falling edge and holds the write strobe for exactly one cycle. It raises the tick only while no posted write is outstanding, so each counter step can be tied to one known tick. Back-to-back writes to one register are issued on purpose, and only in the drop test.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW    = 32;
  localparam int AW    = 3;
  localparam int NSLOT = 4;

  localparam logic [AW-1:0] A_CTRL  = 3'd0;
  localparam logic [AW-1:0] A_LOAD  = 3'd1;
  localparam logic [AW-1:0] A_COUNT = 3'd2;
  localparam logic [AW-1:0] A_KICK  = 3'd3;
  localparam logic [AW-1:0] A_KEY   = 3'd4;
  localparam logic [AW-1:0] A_PEND  = 3'd5;

  localparam int S_CTRL = 0;
  localparam int S_LOAD = 1;
  localparam int S_KICK = 2;
  localparam int S_KEY  = 3;

  localparam logic [DW-1:0] KEY_DIS1 = 32'h0000_AAAA;
  localparam logic [DW-1:0] KEY_DIS2 = 32'h0000_5555;
  localparam logic [DW-1:0] KEY_EN1  = 32'h0000_BBBB;
  localparam logic [DW-1:0] KEY_EN2  = 32'h0000_4444;

  typedef enum logic [1:0] {ARM_NONE, ARM_EN, ARM_DIS} arm_t;

  // maps a bus address to its posting slot; valid=0 for unposted addresses
  function automatic logic [NSLOT-1:0] slot_sel(input logic [AW-1:0] a);
    logic [NSLOT-1:0] s;
    s = '0;
    case (a)
      A_CTRL:  s[S_CTRL] = 1'b1;
      A_LOAD:  s[S_LOAD] = 1'b1;
      A_KICK:  s[S_KICK] = 1'b1;
      A_KEY:   s[S_KEY]  = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
  parameter int DW       = 32,
  parameter int PEND_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          commit_o,
  output logic [DW-1:0] cdata_o
);
  localparam int CW = $clog2(PEND_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic          accept;

  assign busy_o   = (cnt_q != '0);
  assign accept   = wr_i && !busy_o;
  assign commit_o = (cnt_q == CW'(1));
  assign cdata_o  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      cnt_q  <= CW'(PEND_CYC);
      data_q <= wdata_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R4: a write landing on a busy slot leaves the held value alone
  a_r4_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && busy_o) |=> $stable(data_q));
  // R3: an accepted write raises the pending flag on the next cycle
  a_r3_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !busy_o) |=> busy_o);
  // R3: the commit cycle is the last pending cycle
  a_r3_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !busy_o);
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_i,
  input  logic [DW-1:0] key_i,
  output logic          run_o,
  output logic          start_o
);
  arm_t arm_q;
  logic run_q;
  logic stop_evt;

  assign start_o  = commit_i && (key_i == KEY_EN2) && (arm_q == ARM_EN);
  assign stop_evt = commit_i && (key_i == KEY_DIS2) && (arm_q == ARM_DIS);
  assign run_o    = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= ARM_NONE;
      run_q <= 1'b0;
    end else if (commit_i) begin
      if (key_i == KEY_EN1)       arm_q <= ARM_EN;
      else if (key_i == KEY_DIS1) arm_q <= ARM_DIS;
      else                        arm_q <= ARM_NONE;
      if (start_o)       run_q <= 1'b1;
      else if (stop_evt) run_q <= 1'b0;
    end
  end

  // R5: the timer only starts on a committed second enable word
  a_r5_start_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> ($past(commit_i) && ($past(key_i) == KEY_EN2)));
  // R6: the timer only stops on a committed second disable word
  a_r6_stop_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(commit_i) && ($past(key_i) == KEY_DIS2)));
endmodule

// File: rtl/wdt_tick_count.sv
module wdt_tick_count #(
  parameter int CNT_W = 32,
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             pre_en_i,
  input  logic [PTV_W-1:0] ptv_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam int DIV_W = (1 << PTV_W) - 1;

  logic [CNT_W-1:0] count_q;
  logic [DIV_W-1:0] div_q;
  logic             hit, adv, wrap_evt, wrap_q;

  // divider reaches its last state for the chosen exponent
  function automatic logic presc_hit(input logic en, input logic [PTV_W-1:0] e,
                                     input logic [DIV_W-1:0] d);
    logic [DIV_W-1:0] lim;
    lim = (DIV_W'(1) << e) - DIV_W'(1);
    return !en || (d == lim);
  endfunction

  assign hit      = presc_hit(pre_en_i, ptv_i, div_q);
  assign adv      = run_i && tick_i && hit;
  assign wrap_evt = adv && (&count_q);
  assign count_o  = count_q;
  assign wrap_o   = wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      div_q   <= '0;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= wrap_evt && !reload_i;
      if (reload_i || wrap_evt) count_q <= load_i;
      else if (adv)             count_q <= count_q + CNT_W'(1);
      if (!run_i)               div_q <= '0;
      else if (tick_i)          div_q <= hit ? '0 : div_q + DIV_W'(1);
    end
  end

  // R9: a stopped timer with no reload keeps its count
  a_r9_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !reload_i) |=> $stable(count_q));
  // R10: a wrap reloads the counter from the load value
  a_r10_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !reload_i) |=> (wrap_q && (count_q == $past(load_i))));
  // R9: no tick, no change unless reloaded
  a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !reload_i) |=> $stable(count_q));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int PEND_CYC = 4,
  parameter int PTV_W    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_i,
  output logic          wdog_rst_o
);
  localparam int CTRL_W = PTV_W + 1;
  localparam logic [DW-1:0] CTRL_MASK = DW'((1 << CTRL_W) - 1);

  logic [NSLOT-1:0] wr_sel, busy, commit;
  logic [DW-1:0]    cdata [NSLOT];
  logic [DW-1:0]    ctrl_q, load_q, last_kick_q, count;
  logic             run, start, kick_reload;

  assign wr_sel = bus_wr ? slot_sel(bus_addr) : '0;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    wdt_post_slot #(.DW(DW), .PEND_CYC(PEND_CYC)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_sel[i]), .wdata_i(bus_wdata),
      .busy_o(busy[i]), .commit_o(commit[i]), .cdata_o(cdata[i]));
  end

  wdt_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .commit_i(commit[S_KEY]), .key_i(cdata[S_KEY]),
    .run_o(run), .start_o(start));

  assign kick_reload = commit[S_KICK] && (cdata[S_KICK] != last_kick_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      load_q      <= '0;
      last_kick_q <= '0;
    end else begin
      if (commit[S_CTRL] && !run) ctrl_q <= cdata[S_CTRL] & CTRL_MASK;
      if (commit[S_LOAD] && !run) load_q <= cdata[S_LOAD];
      if (commit[S_KICK])         last_kick_q <= cdata[S_KICK];
    end
  end

  wdt_tick_count #(.CNT_W(DW), .PTV_W(PTV_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick_i),
    .pre_en_i(ctrl_q[0]), .ptv_i(ctrl_q[PTV_W:1]),
    .reload_i(start || kick_reload), .load_i(load_q),
    .count_o(count), .wrap_o(wdog_rst_o));

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_LOAD:  bus_rdata = load_q;
      A_COUNT: bus_rdata = count;
      A_KICK:  bus_rdata = last_kick_q;
      A_PEND:  bus_rdata = DW'(busy);
      default: bus_rdata = '0;
    endcase
  end

  // R7: configuration is frozen while the timer runs
  a_r7_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && commit[S_CTRL]) |=> $stable(ctrl_q));
  a_r7_load_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && commit[S_LOAD]) |=> $stable(load_q));
  // R3: configuration registers change only on a commit
  a_r3_load_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit[S_LOAD] |=> $stable(load_q));
endmodule

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;
  localparam int PEND = 4;
  localparam logic [2:0] CTRL = 3'd0, LOAD = 3'd1, COUNT = 3'd2,
                         KICK = 3'd3, KEY = 3'd4, PEND_A = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick = 1'b0;
  logic        wdog_rst;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  logic [31:0] v;

  always #2 clk = ~clk;

  wdt_keyed u_wdt_keyed (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick),
    .wdog_rst_o(wdog_rst));

  // {write addr, write data, read addr, expected read}
  localparam int NV = 8;
  localparam logic [69:0] VEC [NV] = '{
    {LOAD,  32'h0000_0100, LOAD,  32'h0000_0100},  // R2 LOAD writable when stopped
    {CTRL,  32'h0000_0005, CTRL,  32'h0000_0005},  // R2 prescaler on, exponent 2
    {KICK,  32'h0000_1234, COUNT, 32'h0000_0100},  // R8 new kick reloads
    {COUNT, 32'h0000_0055, COUNT, 32'h0000_0100},  // R2 COUNT read-only
    {KEY,   32'h0000_BBBB, COUNT, 32'h0000_0100},  // R5 first enable word
    {KEY,   32'h0000_4444, COUNT, 32'h0000_0100},  // R5 running now
    {LOAD,  32'h0000_0200, LOAD,  32'h0000_0100},  // R7 LOAD locked
    {CTRL,  32'h0000_0000, CTRL,  32'h0000_0005}   // R7 CTRL locked
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] r);
    bus_addr = a;
    #1 r = bus_rdata;
  endtask

  task automatic wr_raw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_post(input logic [2:0] a, input logic [31:0] d);
    wr_raw(a, d);
    repeat (PEND) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(CTRL, v);   chk("R1 ctrl", v, 32'h0);
    rd(LOAD, v);   chk("R1 load", v, 32'h0);
    rd(COUNT, v);  chk("R1 count", v, 32'h0);
    rd(PEND_A, v); chk("R1 pend", v, 32'h0);
    chk("R1 rst_out", {31'b0, wdog_rst}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    ticks(3);
    rd(COUNT, v);  chk("R1 stopped after reset", v, 32'h0);

    for (int k = 0; k < NV; k++) begin
      wr_post(VEC[k][69:67], VEC[k][66:35]);
      rd(VEC[k][34:32], v);
      chk($sformatf("table %0d", k), v, VEC[k][31:0]);
    end

    // R9 prescaled counting: exponent 2, one step per 4 ticks
    ticks(3);  rd(COUNT, v); chk("R9 3 ticks no step", v, 32'h100);
    ticks(1);  rd(COUNT, v); chk("R9 4th tick steps", v, 32'h101);
    ticks(4);  rd(COUNT, v); chk("R9 next step", v, 32'h102);

    // R8 repeated kick ignored, changed kick reloads
    wr_post(KICK, 32'h0000_1234); rd(COUNT, v); chk("R8 same kick ignored", v, 32'h102);
    wr_post(KICK, 32'h0000_EDCB); rd(COUNT, v); chk("R8 new kick reloads", v, 32'h100);

    // R6 wrong orders leave it running
    wr_post(KEY, 32'h0000_5555);
    wr_post(KEY, 32'h0000_AAAA);
    wr_post(KEY, 32'h0000_1111);
    wr_post(KEY, 32'h0000_5555);
    ticks(4); rd(COUNT, v); chk("R6 still running", v, 32'h101);

    // R6 correct stop
    wr_post(KEY, 32'h0000_AAAA);
    wr_post(KEY, 32'h0000_5555);
    ticks(8); rd(COUNT, v); chk("R6 stopped holds", v, 32'h101);

    // R3 / R4 posting and drop
    wr_raw(LOAD, 32'h0000_0300);
    rd(PEND_A, v); chk("R3 pend bit1 set", v, 32'h2);
    wr_raw(LOAD, 32'h0000_0400);
    @(negedge clk);
    rd(PEND_A, v); chk("R3 still pending", v, 32'h2);
    rd(LOAD, v);   chk("R3 not yet applied", v, 32'h100);
    @(negedge clk);
    rd(PEND_A, v); chk("R3 pend cleared", v, 32'h0);
    rd(LOAD, v);   chk("R4 second write dropped", v, 32'h300);

    // R5 enable reload, R10 wrap, prescaler off
    wr_post(LOAD, 32'hFFFF_FFFE);
    wr_post(CTRL, 32'h0);
    wr_post(KEY, 32'h0000_BBBB);
    wr_post(KEY, 32'h0000_4444);
    rd(COUNT, v); chk("R5 enable loads count", v, 32'hFFFF_FFFE);
    ticks(1); rd(COUNT, v); chk("R9 step per tick", v, 32'hFFFF_FFFF);
    chk("R10 no pulse yet", {31'b0, wdog_rst}, 32'h0);
    ticks(1);
    chk("R10 pulse on wrap", {31'b0, wdog_rst}, 32'h1);
    rd(COUNT, v); chk("R10 reload on wrap", v, 32'hFFFF_FFFE);
    @(negedge clk);
    chk("R10 pulse one cycle", {31'b0, wdog_rst}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule